// File: doc/BRIEF.md
# Shared-Track Occupancy Interlock for Two Trains

This block arbitrates a stretch of track that two looped railways have in common. Train A circles an outer loop and train B an inner loop, both counterclockwise, and each loop passes through the same shared section. Four sensors feed the block: one approach sensor per train, which fires as that train nears the shared section, and one clear sensor per train, which fires as it leaves the section. The block drives two outputs per train. The run enable powers or halts the train. The route select sets the points so that the train's loop joins the shared section.

The controller is a five-state Moore machine. In one state the shared section is empty. In two states one train owns it. In two further states one train owns it while the other is held. Outputs are decoded from the state and registered, so they change only at a clock edge: the edge that samples the sensors. A synchronous active-high reset returns the block to the empty state with both trains powered. The sensors are assumed to be synchronized and debounced already, and each pulse lasts at least one clock.

Top module: `track_interlock`

## Requirements
- R1: While reset is high at a clock edge, the outputs after that edge are a_run_o=1, b_run_o=1, a_route_o=0, b_route_o=0. This is the empty state, and reset wins over every sensor.
- R2: a_route_o and b_route_o are never both 1, and a_run_o and b_run_o are never both 0.
- R3: In the empty state, a_near_i alone moves the block to "A owns" after the next edge: a_route_o=1, b_route_o=0, both runs 1.
- R4: In the empty state, b_near_i alone moves the block to "B owns" after the next edge: b_route_o=1, a_route_o=0, both runs 1.
- R5: In the empty state, a_near_i and b_near_i sampled in the same cycle give A the section and hold B: a_route_o=1, a_run_o=1, b_run_o=0, b_route_o=0.
- R6: While A owns the section, b_near_i without a_clear_i holds B: b_run_o=0, and a_route_o stays 1.
- R7: A held B stays stopped, with unchanged outputs, until a_clear_i is sampled. After that edge B owns the section: b_route_o=1, a_route_o=0, both runs 1.
- R8: This mirrors R6 and R7. While B owns the section, a_near_i holds A with a_run_o=0 and b_route_o=1. A later b_clear_i gives A the section: a_route_o=1, b_route_o=0, both runs 1.
- R9: When the owner's clear sensor fires and the other train has no request in that cycle, the block returns to the empty state (1,1,0,0).
- R10: When the owner's clear sensor and the other train's approach sensor are sampled in the same cycle, the other train is granted the section directly with both runs 1.
- R11: Sensors that do not apply to the current state have no effect: clear sensors in the empty state, approach sensors in either held state, and the owner's own approach sensor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| a_near_i | input | 1 | Train A approaching the shared section |
| b_near_i | input | 1 | Train B approaching the shared section |
| a_clear_i | input | 1 | Train A has left the shared section |
| b_clear_i | input | 1 | Train B has left the shared section |
| a_run_o | output | 1 | Train A power, 1 = running |
| b_run_o | output | 1 | Train B power, 1 = running |
| a_route_o | output | 1 | Points set to join the outer loop to the shared section |
| b_route_o | output | 1 | Points set to join the inner loop to the shared section |

## Verification
The hardest situations to reach are the coincidences. The first is a clear pulse from the owner landing in the same cycle as the other train's approach. The second is both approach sensors firing together from the empty state. The third is a fresh approach pulse arriving while a train is already held. The vector table steps through each of these in turn from a known state, holding every input for exactly one cycle. It then walks through each of the held states and finishes with a reset applied during a held state while sensors are high.

// File: rtl/interlock_pkg.sv
package interlock_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY  = 3'd0,
    ST_A_OWN  = 3'd1,
    ST_B_OWN  = 3'd2,
    ST_A_BWAIT = 3'd3,   // A owns, B held
    ST_B_AWAIT = 3'd4    // B owns, A held
  } occ_state_e;

  typedef struct packed {
    logic a_near;
    logic b_near;
    logic a_clear;
    logic b_clear;
  } sensor_t;

  typedef struct packed {
    logic a_run;
    logic b_run;
    logic a_route;
    logic b_route;
  } drive_t;

  localparam int DRIVE_W = $bits(drive_t);

  // Moore output decode: one drive pattern per state
  function automatic drive_t drive_of(input occ_state_e s);
    drive_t d;
    case (s)
      ST_A_OWN:   d = drive_t'(4'b1110);
      ST_B_OWN:   d = drive_t'(4'b1101);
      ST_A_BWAIT: d = drive_t'(4'b1010);
      ST_B_AWAIT: d = drive_t'(4'b0101);
      default:    d = drive_t'(4'b1100);
    endcase
    return d;
  endfunction

  function automatic logic a_owns(input occ_state_e s);
    return (s == ST_A_OWN) || (s == ST_A_BWAIT);
  endfunction

  function automatic logic b_owns(input occ_state_e s);
    return (s == ST_B_OWN) || (s == ST_B_AWAIT);
  endfunction

  // Transition rule; A wins a same-cycle tie from the empty state
  function automatic occ_state_e next_of(input occ_state_e s, input sensor_t x);
    occ_state_e n;
    n = s;
    case (s)
      ST_EMPTY: begin
        if (x.a_near && x.b_near) n = ST_A_BWAIT;
        else if (x.a_near)        n = ST_A_OWN;
        else if (x.b_near)        n = ST_B_OWN;
      end
      ST_A_OWN: begin
        if (x.a_clear)     n = x.b_near ? ST_B_OWN : ST_EMPTY;
        else if (x.b_near) n = ST_A_BWAIT;
      end
      ST_B_OWN: begin
        if (x.b_clear)     n = x.a_near ? ST_A_OWN : ST_EMPTY;
        else if (x.a_near) n = ST_B_AWAIT;
      end
      ST_A_BWAIT: if (x.a_clear) n = ST_B_OWN;
      ST_B_AWAIT: if (x.b_clear) n = ST_A_OWN;
      default: n = ST_EMPTY;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/il_arbiter.sv
module il_arbiter
  import interlock_pkg::*;
(
  input  occ_state_e cur_i,
  input  sensor_t    sens_i,
  output occ_state_e nxt_o,
  output logic       grant_a_o,
  output logic       grant_b_o
);
  always_comb begin
    nxt_o     = next_of(cur_i, sens_i);
    grant_a_o = a_owns(nxt_o) && !a_owns(cur_i);
    grant_b_o = b_owns(nxt_o) && !b_owns(cur_i);
  end
endmodule

// File: rtl/il_state_reg.sv
module il_state_reg
  import interlock_pkg::*;
#(
  parameter occ_state_e RESET_STATE = ST_EMPTY
)(
  input  logic       clk_i,
  input  logic       rst_i,
  input  occ_state_e nxt_i,
  output occ_state_e cur_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) cur_o <= RESET_STATE;
    else       cur_o <= nxt_i;
  end
endmodule

// File: rtl/il_drive_reg.sv
module il_drive_reg
  import interlock_pkg::*;
#(
  parameter occ_state_e RESET_STATE = ST_EMPTY
)(
  input  logic       clk_i,
  input  logic       rst_i,
  input  occ_state_e nxt_i,
  output drive_t     drv_o
);
  // registered from the next state so outputs move on the same edge as the state
  always_ff @(posedge clk_i) begin
    if (rst_i) drv_o <= drive_of(RESET_STATE);
    else       drv_o <= drive_of(nxt_i);
  end
endmodule

// File: rtl/track_interlock.sv
module track_interlock
  import interlock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic a_near_i,
  input  logic b_near_i,
  input  logic a_clear_i,
  input  logic b_clear_i,
  output logic a_run_o,
  output logic b_run_o,
  output logic a_route_o,
  output logic b_route_o
);
  localparam occ_state_e IDLE_ST = ST_EMPTY;

  sensor_t    sens;
  occ_state_e cur_st;
  occ_state_e nxt_st;
  drive_t     drv;
  logic       grant_a;
  logic       grant_b;

  assign sens = '{a_near: a_near_i, b_near: b_near_i,
                  a_clear: a_clear_i, b_clear: b_clear_i};

  il_arbiter u_arb (
    .cur_i(cur_st), .sens_i(sens), .nxt_o(nxt_st),
    .grant_a_o(grant_a), .grant_b_o(grant_b)
  );

  il_state_reg #(.RESET_STATE(IDLE_ST)) u_st (
    .clk_i(clk_i), .rst_i(rst_i), .nxt_i(nxt_st), .cur_o(cur_st)
  );

  il_drive_reg #(.RESET_STATE(IDLE_ST)) u_drv (
    .clk_i(clk_i), .rst_i(rst_i), .nxt_i(nxt_st), .drv_o(drv)
  );

  assign a_run_o   = drv.a_run;
  assign b_run_o   = drv.b_run;
  assign a_route_o = drv.a_route;
  assign b_route_o = drv.b_route;
endmodule

// File: rtl/track_interlock_chk.sv
module track_interlock_chk (
  input logic clk_i,
  input logic rst_i,
  input logic a_near_i,
  input logic b_near_i,
  input logic a_clear_i,
  input logic b_clear_i,
  input logic a_run_o,
  input logic b_run_o,
  input logic a_route_o,
  input logic b_route_o,
  input logic grant_a,
  input logic grant_b
);
  logic empty_now;
  assign empty_now = a_run_o && b_run_o && !a_route_o && !b_route_o;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> empty_now);

  // R2
  one_owner_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(a_route_o && b_route_o));

  // R2
  one_halted_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    a_run_o || b_run_o);

  // R3
  grant_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    empty_now && a_near_i && !b_near_i |=> a_route_o && a_run_o && b_run_o);

  // R5
  tie_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    empty_now && a_near_i && b_near_i |=> a_route_o && !b_run_o);

  // R7
  b_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !b_run_o && !a_clear_i |=> !b_run_o && a_route_o);

  // R7
  b_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !b_run_o && a_clear_i |=> b_route_o && a_run_o && b_run_o);

  // R8
  a_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !a_run_o && !b_clear_i |=> !a_run_o && b_route_o);

  // R8
  a_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !a_run_o && b_clear_i |=> a_route_o && a_run_o && b_run_o);

  // R10
  grant_a_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    grant_a |=> a_route_o && !b_route_o);

  // R10
  grant_b_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    grant_b |=> b_route_o && !a_route_o);
endmodule

bind track_interlock track_interlock_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i),
  .a_near_i(a_near_i), .b_near_i(b_near_i),
  .a_clear_i(a_clear_i), .b_clear_i(b_clear_i),
  .a_run_o(a_run_o), .b_run_o(b_run_o),
  .a_route_o(a_route_o), .b_route_o(b_route_o),
  .grant_a(grant_a), .grant_b(grant_b)
);

// File: tb/track_interlock_test.sv
`timescale 1ns/1ps
module track_interlock_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic an = 1'b0, bn = 1'b0, ac = 1'b0, bc = 1'b0;
  logic ar, br, ra, rb;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  track_interlock uut (
    .clk_i(clk), .rst_i(rst), .a_near_i(an), .b_near_i(bn),
    .a_clear_i(ac), .b_clear_i(bc), .a_run_o(ar), .b_run_o(br),
    .a_route_o(ra), .b_route_o(rb)
  );

  // entry: {rst,an,bn,ac,bc}_{a_run,b_run,a_route,b_route}_{req}
  localparam int NV = 18;
  localparam logic [12:0] VEC [NV] = '{
    13'b10000_1100_0001,  // R1 reset
    13'b00011_1100_1011,  // R11 clears ignored when empty
    13'b01000_1110_0011,  // R3 A alone
    13'b00100_1010_0110,  // R6 B held behind A
    13'b01100_1010_1011,  // R11 approaches ignored while held
    13'b00000_1010_0111,  // R7 B stays stopped
    13'b00010_1101_0111,  // R7 A clears, B owns
    13'b01000_0101_1000,  // R8 A held behind B
    13'b00100_0101_1011,  // R11 approach ignored while held
    13'b00001_1110_1000,  // R8 B clears, A owns
    13'b00010_1100_1001,  // R9 back to empty
    13'b00100_1101_0100,  // R4 B alone
    13'b01001_1110_1010,  // R10 B clears as A approaches
    13'b00110_1101_1010,  // R10 A clears as B approaches
    13'b00001_1100_1001,  // R9 back to empty
    13'b01100_1010_0101,  // R5 tie goes to A
    13'b00010_1101_0111,  // R7 release after tie
    13'b00001_1100_1001   // R9 empty again
  };

  task automatic check(input logic [3:0] exp, input int req);
    n_run++;
    if ({ar, br, ra, rb} !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got run/route %b expected %b", req, {ar, br, ra, rb}, exp);
    end
  endtask

  task automatic step(input logic [4:0] ins, input logic [3:0] exp, input int req);
    @(negedge clk);
    {rst, an, bn, ac, bc} = ins;
    @(posedge clk);
    #2;
    check(exp, req);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++)
      step(VEC[i][12:8], VEC[i][7:4], int'(VEC[i][3:0]));

    // R1: reset while B held and sensors active
    step(5'b01100, 4'b1010, 5);
    step(5'b11111, 4'b1100, 1);
    // R3 after reset release
    step(5'b01000, 4'b1110, 3);
    // R11: owner's own approach ignored
    step(5'b01000, 4'b1110, 11);
    // R9
    step(5'b00010, 4'b1100, 9);
    // R4 then R8 hold and check stable mid-cycle
    step(5'b00100, 4'b1101, 4);
    step(5'b01000, 4'b0101, 8);
    #3 check(4'b0101, 8);
    step(5'b00000, 4'b0101, 8);
    step(5'b00001, 4'b1110, 8);
    step(5'b00000, 4'b1110, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule